// File: doc/BRIEF.md
# Packed Lane Saturating Adder

This block performs lane-parallel arithmetic on two 32-bit operands that each hold packed integers. A format select splits each operand into four 8-bit lanes or two 16-bit lanes. A sign select decides whether every lane is read as a signed or an unsigned number. Each lane is widened before any arithmetic. Lanes never pass carries to one another.

Five operations are available. Add and subtract either clamp to the lane range or wrap. Halving add and halving subtract shift the wide sum right by one, with optional rounding. Absolute value replaces each lane with its magnitude. The packed result leaves a register one cycle after the input strobe. A one-cycle overflow pulse goes with it, and the parent status register ORs that pulse into its sticky flag.

Top module: `simd_sat_addsub`

## Requirements
- R1: With `fmt_half`=0 the lanes are bits [8i+7:8i] for i=0..3. With `fmt_half`=1 the lanes are bits [16i+15:16i] for i=0..1. Each lane result depends only on the same lane of `a` and `b`.
- R2: With `is_signed`=1 the lanes are sign-extended and the lane range is -2^(W-1)..2^(W-1)-1. With `is_signed`=0 the lanes are zero-extended and the range is 0..2^(W-1+1)-1. W is the lane width: 8 gives -128..127 or 0..255, and 16 gives -32768..32767 or 0..65535.
- R3: Add (`op`=0, a+b) and subtract (`op`=1, a-b) with `saturate`=1 apply to each lane. A lane whose true result is above the range maximum returns the maximum. A lane below the minimum returns the minimum. Either case raises overflow.
- R4: Add and subtract with `saturate`=0 return the low W bits of the true lane result. Overflow is still raised when that true result is out of range.
- R5: Halving add (`op`=2) and halving subtract (`op`=3) return (a±b+`round_en`) arithmetically shifted right by one, computed at full width. They never raise overflow.
- R6: Absolute value (`op`=4) always reads the lanes of `a` as signed, whatever `is_signed` says, and ignores `b`. The most negative lane value returns the most positive value and raises overflow. Other negative lanes are negated, and non-negative lanes pass unchanged.
- R7: `ovf` is the OR of all lane overflows. It is high for exactly the one cycle in which `out_valid` presents that operation.
- R8: `out_valid` rises on the clock edge after an edge that samples `in_valid`=1, and `result` updates on that same edge. While `in_valid` is 0, `result` holds its value, and `out_valid` and `ovf` are 0.
- R9: While `rst_n` is 0 at a clock edge, `result` becomes 0 and `out_valid` and `ovf` become 0.
- R10: Opcodes 5 to 7 return a zero result with no overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operand strobe |
| op | input | 3 | 0 add, 1 sub, 2 halving add, 3 halving sub, 4 absolute |
| fmt_half | input | 1 | 0: four 8-bit lanes, 1: two 16-bit lanes |
| is_signed | input | 1 | Signed lane interpretation |
| saturate | input | 1 | Clamp add/sub results |
| round_en | input | 1 | Round halving results |
| a | input | 32 | First packed operand |
| b | input | 32 | Second packed operand |
| out_valid | output | 1 | Result strobe |
| result | output | 32 | Packed lane results |
| ovf | output | 1 | Overflow pulse for this result |

## Verification
Every result, overflow pulse and valid strobe is due at the first rising edge after the edge that samples the operands, with one register on the path. The bench drives operands at the falling edge. It compares all three outputs with a behavioural integer model shortly after the next rising edge. Back-to-back operations are checked edge by edge in this way. Idle cycles are checked at the same point, and there `result` must equal its previous value while the strobes stay low.

// File: rtl/simd_sat_pkg.sv
// Shared definitions for the packed lane adder.
// Assumes the operand word is 32 bits and lanes divide it evenly.
package simd_sat_pkg;
    localparam int WORD_W = 32;

    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_SUB  = 3'd1,
        OP_HADD = 3'd2,
        OP_HSUB = 3'd3,
        OP_ABS  = 3'd4
    } lane_op_e;
endpackage

// File: rtl/simd_lane.sv
// One lane of the packed adder: it widens both operands, computes the
// selected operation and range-checks the result. With saturation on it
// clamps the result to the lane limits.
// Assumes LANE_W <= 30 so that the limits fit a 32-bit int.
module simd_lane
    import simd_sat_pkg::*;
#(
    parameter int LANE_W = 8
) (
    input  logic [LANE_W-1:0] x,
    input  logic [LANE_W-1:0] y,
    input  logic [2:0]        op,
    input  logic              sgn,
    input  logic              sat,
    input  logic              rnd,
    output logic [LANE_W-1:0] r,
    output logic              ovf
);
    localparam int EW = LANE_W + 2;
    localparam logic signed [EW-1:0] S_MAX = EW'((1 << (LANE_W - 1)) - 1);
    localparam logic signed [EW-1:0] S_MIN = -S_MAX - EW'(1);
    localparam logic signed [EW-1:0] U_MAX = EW'((1 << LANE_W) - 1);
    localparam logic signed [EW-1:0] U_MIN = '0;

    logic              use_sgn;
    logic signed [EW-1:0] ex, ey, wide, neg_x, hi, lo, rnd_w;
    logic              above, below, ranged;

    // Widen both operands with sign or zero extension.
    always_comb begin
        use_sgn = sgn | (op == OP_ABS);
        ex      = use_sgn ? {{2{x[LANE_W-1]}}, x} : {2'b00, x};
        ey      = use_sgn ? {{2{y[LANE_W-1]}}, y} : {2'b00, y};
        hi      = use_sgn ? S_MAX : U_MAX;
        lo      = use_sgn ? S_MIN : U_MIN;
        rnd_w   = {{(EW-1){1'b0}}, rnd};
        neg_x   = -ex;
    end

    // Form the full-width lane value for the selected operation.
    always_comb begin
        case (op)
            OP_ADD:  wide = ex + ey;
            OP_SUB:  wide = ex - ey;
            OP_HADD: wide = ex + ey + rnd_w;
            OP_HSUB: wide = ex - ey + rnd_w;
            default: wide = ex;
        endcase
    end

    // Range-check, then clamp, wrap, halve or take the magnitude.
    always_comb begin
        above  = wide > hi;
        below  = wide < lo;
        ranged = (op == OP_ADD) || (op == OP_SUB);
        r      = '0;
        ovf    = 1'b0;
        if (ranged) begin
            ovf = above | below;
            if (sat && above)      r = hi[LANE_W-1:0];
            else if (sat && below) r = lo[LANE_W-1:0];
            else                   r = wide[LANE_W-1:0];
        end else if ((op == OP_HADD) || (op == OP_HSUB)) begin
            r = wide[LANE_W:1];
        end else if (op == OP_ABS) begin
            if (ex == S_MIN) begin
                r   = S_MAX[LANE_W-1:0];
                ovf = 1'b1;
            end else if (ex[EW-1]) begin
                r = neg_x[LANE_W-1:0];
            end else begin
                r = ex[LANE_W-1:0];
            end
        end
    end
endmodule

// File: rtl/simd_lane_array.sv
// Splits the operand words into lanes of one width and runs a lane unit on
// each of them. It repacks the lane results and ORs the lane overflows.
// Assumes the word width is a multiple of LANE_W.
module simd_lane_array
    import simd_sat_pkg::*;
#(
    parameter int LANE_W = 8,
    parameter int WIDTH  = WORD_W
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic [2:0]       op,
    input  logic             sgn,
    input  logic             sat,
    input  logic             rnd,
    output logic [WIDTH-1:0] r,
    output logic             ovf
);
    localparam int N_LANES = WIDTH / LANE_W;

    logic [N_LANES-1:0] lane_ovf;

    for (genvar i = 0; i < N_LANES; i++) begin : g_lane
        simd_lane #(.LANE_W(LANE_W)) u_lane (
            .x   (a[i*LANE_W +: LANE_W]),
            .y   (b[i*LANE_W +: LANE_W]),
            .op  (op),
            .sgn (sgn),
            .sat (sat),
            .rnd (rnd),
            .r   (r[i*LANE_W +: LANE_W]),
            .ovf (lane_ovf[i])
        );
    end

    // Any lane out of range flags the whole operation.
    always_comb ovf = |lane_ovf;
endmodule

// File: rtl/simd_sat_addsub.sv
// Top of the packed lane adder. It runs a byte-lane array and a
// halfword-lane array in parallel and picks one by format. The chosen
// result and overflow are registered behind the input strobe.
// Assumes a synchronous active-low reset.
module simd_sat_addsub
    import simd_sat_pkg::*;
#(
    parameter int WIDTH  = WORD_W,
    parameter int NARROW = 8,
    parameter int WIDE   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [2:0]       op,
    input  logic             fmt_half,
    input  logic             is_signed,
    input  logic             saturate,
    input  logic             round_en,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic             out_valid,
    output logic [WIDTH-1:0] result,
    output logic             ovf
);
    logic [WIDTH-1:0] r_nar, r_wid, r_sel;
    logic             o_nar, o_wid, o_sel;

    simd_lane_array #(.LANE_W(NARROW), .WIDTH(WIDTH)) u_nar (
        .a(a), .b(b), .op(op), .sgn(is_signed), .sat(saturate),
        .rnd(round_en), .r(r_nar), .ovf(o_nar)
    );

    simd_lane_array #(.LANE_W(WIDE), .WIDTH(WIDTH)) u_wid (
        .a(a), .b(b), .op(op), .sgn(is_signed), .sat(saturate),
        .rnd(round_en), .r(r_wid), .ovf(o_wid)
    );

    // Pick the lane format the caller asked for.
    always_comb begin
        r_sel = fmt_half ? r_wid : r_nar;
        o_sel = fmt_half ? o_wid : o_nar;
    end

    // Output stage: capture on strobe and emit a single overflow pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            ovf       <= 1'b0;
            result    <= '0;
        end else begin
            out_valid <= in_valid;
            ovf       <= in_valid & o_sel;
            if (in_valid) result <= r_sel;
        end
    end
endmodule

// File: rtl/simd_sat_addsub_chk.sv
// Timing and protocol properties of the packed lane adder, bound to the top.
module simd_sat_addsub_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [2:0]  op,
    input logic        out_valid,
    input logic [31:0] result,
    input logic        ovf
);
    p_valid_lat_r8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(result)));
    p_ovf_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |-> out_valid);
    p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (op == 3'd2 || op == 3'd3)) |=> !ovf);
    p_bad_op_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op > 3'd4) |=> (result == 32'd0 && !ovf));
endmodule

bind simd_sat_addsub simd_sat_addsub_chk u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
    .out_valid(out_valid), .result(result), .ovf(ovf)
);

// File: tb/simd_sat_addsub_bench.sv
`timescale 1ns/1ps
module simd_sat_addsub_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  op = '0;
    logic        fmt_half = 1'b0, is_signed = 1'b0, saturate = 1'b0, round_en = 1'b0;
    logic [31:0] a = '0, b = '0;
    logic        out_valid, ovf;
    logic [31:0] result;
    int checks = 0, errors = 0;

    always #2.5 clk = ~clk;

    simd_sat_addsub u_simd_sat_addsub (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
        .fmt_half(fmt_half), .is_signed(is_signed), .saturate(saturate),
        .round_en(round_en), .a(a), .b(b), .out_valid(out_valid),
        .result(result), .ovf(ovf)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Behavioural reference in plain integers.
    function automatic void model(input logic [31:0] ia, input logic [31:0] ib,
                                  input logic [2:0] iop, input logic fm, input logic sg,
                                  input logic st, input logic rd,
                                  output logic [31:0] r, output logic ov);
        longint w, n, mask, ua, ub, x, y, s, hi, lo, lr;
        bit sgn_eff;
        w = fm ? 16 : 8;
        n = 32 / w;
        mask = (64'sd1 <<< w) - 1;
        r = '0;
        ov = 1'b0;
        sgn_eff = sg || (iop == 3'd4);
        hi = sgn_eff ? ((64'sd1 <<< (w - 1)) - 1) : mask;
        lo = sgn_eff ? -(64'sd1 <<< (w - 1)) : 0;
        for (int i = 0; i < n; i++) begin
            ua = (longint'(ia) >>> (i * w)) & mask;
            ub = (longint'(ib) >>> (i * w)) & mask;
            x = (sgn_eff && ua > hi) ? ua - (mask + 1) : ua;
            y = (sgn_eff && ub > hi) ? ub - (mask + 1) : ub;
            lr = 0;
            case (iop)
                3'd0, 3'd1: begin
                    s = (iop == 3'd0) ? x + y : x - y;
                    if (s > hi || s < lo) ov = 1'b1;
                    if (st && s > hi) lr = hi;
                    else if (st && s < lo) lr = lo;
                    else lr = s;
                end
                3'd2: lr = (x + y + rd) >>> 1;
                3'd3: lr = (x - y + rd) >>> 1;
                3'd4: begin
                    if (x == lo) begin lr = hi; ov = 1'b1; end
                    else lr = (x < 0) ? -x : x;
                end
                default: lr = 0;
            endcase
            r = r | 32'((lr & mask) << (i * w));
        end
    endfunction

    task automatic run(input string tag, input logic [31:0] ia, input logic [31:0] ib,
                       input logic [2:0] iop, input logic fm, input logic sg,
                       input logic st, input logic rd);
        logic [31:0] er;
        logic eo;
        @(negedge clk);
        a = ia; b = ib; op = iop; fmt_half = fm; is_signed = sg;
        saturate = st; round_en = rd; in_valid = 1'b1;
        model(ia, ib, iop, fm, sg, st, rd, er, eo);
        @(posedge clk);
        #1;
        chk({tag, " valid"}, {31'd0, out_valid}, 32'd1);
        chk({tag, " result"}, result, er);
        chk({tag, " ovf"}, {31'd0, ovf}, {31'd0, eo});
    endtask

    task automatic idle(input string tag);
        logic [31:0] prev;
        @(negedge clk);
        in_valid = 1'b0;
        a = 32'hDEAD_BEEF; b = 32'h1234_5678;
        prev = result;
        @(posedge clk);
        #1;
        chk({tag, " valid low"}, {31'd0, out_valid}, 32'd0);
        chk({tag, " ovf low"}, {31'd0, ovf}, 32'd0);
        chk({tag, " hold"}, result, prev);
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        #1;
        chk("R9 reset valid", {31'd0, out_valid}, 32'd0);
        chk("R9 reset ovf", {31'd0, ovf}, 32'd0);
        chk("R9 reset result", result, 32'd0);
        @(negedge clk) rst_n = 1'b1;
        idle("R8 idle after reset");

        // R3: saturating add and subtract, both signs and both formats
        run("R3 u8 sat add", 32'h10FF_807F, 32'h0101_8001, 3'd0, 1'b0, 1'b0, 1'b1, 1'b0);
        run("R3 s8 sat add", 32'h7F80_0140, 32'h01FF_0140, 3'd0, 1'b0, 1'b1, 1'b1, 1'b0);
        run("R3 s8 sat sub", 32'h8000_7F05, 32'h0101_FF03, 3'd1, 1'b0, 1'b1, 1'b1, 1'b0);
        run("R3 u8 sat sub", 32'h0005_FF10, 32'h0106_0020, 3'd1, 1'b0, 1'b0, 1'b1, 1'b0);
        run("R3 s16 sat add", 32'h7FFF_8000, 32'h0001_FFFF, 3'd0, 1'b1, 1'b1, 1'b1, 1'b0);
        run("R2 u16 sat add", 32'hFFFF_1234, 32'h0001_0001, 3'd0, 1'b1, 1'b0, 1'b1, 1'b0);
        // R4: wrapping but still flagged
        run("R4 s8 wrap add", 32'h7F00_0000, 32'h0100_0000, 3'd0, 1'b0, 1'b1, 1'b0, 1'b0);
        run("R4 u16 wrap sub", 32'h0000_0003, 32'h0001_0001, 3'd1, 1'b1, 1'b0, 1'b0, 1'b0);
        run("R4 no ovf in range", 32'h0102_0304, 32'h0101_0101, 3'd0, 1'b0, 1'b1, 1'b0, 1'b0);
        // R1: lanes do not pass carries
        run("R1 u8 lane isolation", 32'h0000_FFFF, 32'h0000_0001, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0);
        run("R1 u16 lane isolation", 32'h0000_FFFF, 32'h0000_0001, 3'd0, 1'b1, 1'b0, 1'b0, 1'b0);
        // R5: halving with and without rounding
        run("R5 s8 hadd trunc", 32'hFD7F_7F03, 32'h0001_7F00, 3'd2, 1'b0, 1'b1, 1'b0, 1'b0);
        run("R5 s8 hadd round", 32'hFD7F_7F03, 32'h0001_7F00, 3'd2, 1'b0, 1'b1, 1'b0, 1'b1);
        run("R5 u8 hsub", 32'h00FF_0510, 32'h0500_0003, 3'd3, 1'b0, 1'b0, 1'b1, 1'b1);
        run("R5 s16 hsub round", 32'h8000_7FFF, 32'h7FFF_8000, 3'd3, 1'b1, 1'b1, 1'b0, 1'b1);
        // R6: absolute value, signed regardless of sign select
        run("R6 abs s8", 32'h80FF_7F00, 32'hFFFF_FFFF, 3'd4, 1'b0, 1'b0, 1'b0, 1'b0);
        run("R6 abs s16", 32'h8000_FFFE, 32'h0000_0000, 3'd4, 1'b1, 1'b1, 1'b1, 1'b0);
        run("R6 abs no ovf", 32'h8100_0102, 32'h0000_0000, 3'd4, 1'b0, 1'b1, 1'b0, 1'b0);
        // R10: unused opcodes
        run("R10 op5", 32'hFFFF_FFFF, 32'h1111_1111, 3'd5, 1'b0, 1'b1, 1'b1, 1'b0);
        run("R10 op7", 32'h8000_8000, 32'h8000_8000, 3'd7, 1'b1, 1'b1, 1'b0, 1'b1);
        idle("R8 hold after stream");
        idle("R7 ovf stays low");

        // R7 R8: random stream mixing idle cycles
        for (int k = 0; k < 400; k++) begin
            if ($urandom_range(0, 4) == 0) idle("R8 random idle");
            else run("R7 random", $urandom, $urandom, 3'($urandom_range(0, 5)),
                     1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
        end

        // R9: reset in mid-stream clears the outputs
        @(negedge clk);
        rst_n = 1'b0; in_valid = 1'b1;
        @(posedge clk);
        #1;
        chk("R9 mid reset result", result, 32'd0);
        chk("R9 mid reset valid", {31'd0, out_valid}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1; in_valid = 1'b0;
        idle("R8 idle after second reset");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule